// File: doc/BRIEF.md
# Watchpoint Address Match Unit

This block gives the debug logic a way to trap on chosen memory traffic. It holds two watch registers. Each one has a word-aligned physical target address and three separate enables: one for instruction fetches, one for loads and one for stores. The pipeline gives the block one access descriptor per cycle: a valid strobe, an access type and a physical address. One cycle later the block reports whether any enabled watch hit that access.

A shared mask register holds a single don't-care field. It also holds one apply bit per watch. When a watch's apply bit is set, address bits that are 1 in the mask field are left out of that watch's comparison, so the watch covers an aligned power-of-two range. A hit raises a one-cycle exception request. The request carries a 5-bit cause code, 16 for a fetch and 23 for a load or store, and a 2-bit field that names the watch or watches that fired. Software loads the registers through a simple select/data write port.

Top module: `watch_match_unit`

## Requirements
- R1: After reset, all watch enables and mask apply bits are cleared, and exc_o, exc_code_o and exc_watch_o are 0. No access raises an exception until a watch is programmed.
- R2: Writes use wr_sel_i. A value of 0 writes watch 0 and 1 writes watch 1; in both, data bit 63 enables stores, bit 62 enables loads, bit 61 enables fetches, and bits 35:2 hold the target address. A value of 2 writes the mask register, with the don't-care field in bits 35:2 and the apply bit for watch n in bit n. A value of 3 is ignored.
- R3: Address bits 1:0 never take part in a comparison. Bits 35:2 must all be equal, except bits whose mask bit is 1 when that watch's apply bit is set.
- R4: Access type encoding is 0 = fetch, 1 = load, 2 = store and 3 = reserved. A watch hits only when the enable for that access type is set. A reserved type never hits.
- R5: exc_o pulses high in the cycle after an accepted access (valid_i high) that hits at least one watch. No exception follows a cycle with valid_i low.
- R6: exc_code_o is 16 for a fetch hit and 23 for a load or store hit. A fetch hit takes priority.
- R7: Bit n of exc_watch_o is set when watch n hit. Both bits are set when both watches hit the same access.
- R8: When exc_o is low, exc_code_o and exc_watch_o are 0.
- R9: A register write and an access in the same cycle compare against the values held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 watch0, 1 watch1, 2 mask |
| wr_data_i | input | 64 | Register write data |
| acc_valid_i | input | 1 | Access descriptor valid |
| acc_type_i | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| acc_addr_i | input | 36 | Physical byte address of the access |
| exc_o | output | 1 | One-cycle exception request |
| exc_code_o | output | 5 | Cause code, 16 or 23 |
| exc_watch_o | output | 2 | Watch that hit, bit n for watch n |

## Verification
The bench builds the block with its default values: a 36-bit physical address, word granularity from bit 2, and two watches. These values make the 36-bit address corners reachable, such as targets above 4 GiB. They also make dual-watch cause reporting reachable. With a 4-bit mask, the bench reaches the edges of a 64-byte range on one watch. On the other watch it shows that an exact compare with the apply bit clear rejects a neighbouring word.

// File: rtl/watch_pkg.sv
package watch_pkg;
  localparam int unsigned PADDR_W_DEF = 36;
  localparam int unsigned WORD_LSB_DEF = 2;
  localparam int unsigned N_WATCH_DEF = 2;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_type_e;

  localparam logic [4:0] CODE_IWATCH = 5'd16;
  localparam logic [4:0] CODE_DWATCH = 5'd23;

  localparam int unsigned BIT_ST_EN = 63;
  localparam int unsigned BIT_LD_EN = 62;
  localparam int unsigned BIT_IF_EN = 61;

  localparam logic [1:0] SEL_W0   = 2'd0;
  localparam logic [1:0] SEL_W1   = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;
endpackage

// File: rtl/watch_regs.sv
module watch_regs
  import watch_pkg::*;
#(
  parameter int unsigned PADDR_W  = PADDR_W_DEF,
  parameter int unsigned WORD_LSB = WORD_LSB_DEF,
  parameter int unsigned N_WATCH  = N_WATCH_DEF,
  localparam int unsigned AW = PADDR_W - WORD_LSB
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [1:0]                     wr_sel_i,
  input  logic [63:0]                    wr_data_i,
  output logic [N_WATCH-1:0]             st_en_o,
  output logic [N_WATCH-1:0]             ld_en_o,
  output logic [N_WATCH-1:0]             if_en_o,
  output logic [N_WATCH-1:0][AW-1:0]     waddr_o,
  output logic [AW-1:0]                  mask_o,
  output logic [N_WATCH-1:0]             apply_o
);
  for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_en_o[g] <= 1'b0;
        ld_en_o[g] <= 1'b0;
        if_en_o[g] <= 1'b0;
        waddr_o[g] <= '0;
      end else if (wr_en_i && wr_sel_i == 2'(g)) begin
        st_en_o[g] <= wr_data_i[BIT_ST_EN];
        ld_en_o[g] <= wr_data_i[BIT_LD_EN];
        if_en_o[g] <= wr_data_i[BIT_IF_EN];
        waddr_o[g] <= wr_data_i[PADDR_W-1:WORD_LSB];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o  <= '0;
      apply_o <= '0;
    end else if (wr_en_i && wr_sel_i == SEL_MASK) begin
      mask_o  <= wr_data_i[PADDR_W-1:WORD_LSB];
      apply_o <= wr_data_i[N_WATCH-1:0];
    end
  end
endmodule

// File: rtl/watch_cmp.sv
module watch_cmp
  import watch_pkg::*;
#(
  parameter int unsigned AW = PADDR_W_DEF - WORD_LSB_DEF
) (
  input  logic [1:0]    acc_type_i,
  input  logic [AW-1:0] acc_word_i,
  input  logic          st_en_i,
  input  logic          ld_en_i,
  input  logic          if_en_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [AW-1:0] mask_i,
  input  logic          apply_i,
  output logic          hit_o
);
  logic [AW-1:0] care;
  logic          addr_eq;
  logic          type_ok;

  assign care    = apply_i ? ~mask_i : '1;
  assign addr_eq = ((acc_word_i ^ waddr_i) & care) == '0;

  always_comb begin
    unique case (acc_type_i)
      ACC_FETCH: type_ok = if_en_i;
      ACC_LOAD:  type_ok = ld_en_i;
      ACC_STORE: type_ok = st_en_i;
      default:   type_ok = 1'b0;
    endcase
  end

  assign hit_o = type_ok & addr_eq;
endmodule

// File: rtl/watch_report.sv
module watch_report
  import watch_pkg::*;
#(
  parameter int unsigned N_WATCH = N_WATCH_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic [1:0]         acc_type_i,
  input  logic [N_WATCH-1:0] hit_i,
  output logic               exc_o,
  output logic [4:0]         exc_code_o,
  output logic [N_WATCH-1:0] exc_watch_o
);
  logic       fire;
  logic [4:0] code_d;

  assign fire   = acc_valid_i & (|hit_i);
  // one access per cycle: a fetch hit outranks any data hit
  assign code_d = (acc_type_i == ACC_FETCH) ? CODE_IWATCH : CODE_DWATCH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_o       <= 1'b0;
      exc_code_o  <= '0;
      exc_watch_o <= '0;
    end else begin
      exc_o       <= fire;
      exc_code_o  <= fire ? code_d : '0;
      exc_watch_o <= fire ? hit_i : '0;
    end
  end
endmodule

// File: rtl/watch_match_unit.sv
module watch_match_unit
  import watch_pkg::*;
#(
  parameter int unsigned PADDR_W  = PADDR_W_DEF,
  parameter int unsigned WORD_LSB = WORD_LSB_DEF,
  localparam int unsigned N_WATCH = 2,
  localparam int unsigned AW      = PADDR_W - WORD_LSB
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [63:0]        wr_data_i,
  input  logic               acc_valid_i,
  input  logic [1:0]         acc_type_i,
  input  logic [PADDR_W-1:0] acc_addr_i,
  output logic               exc_o,
  output logic [4:0]         exc_code_o,
  output logic [1:0]         exc_watch_o
);
  logic [N_WATCH-1:0]         st_en, ld_en, if_en, apply, hit;
  logic [N_WATCH-1:0][AW-1:0] waddr;
  logic [AW-1:0]              mask;

  watch_regs #(.PADDR_W(PADDR_W), .WORD_LSB(WORD_LSB), .N_WATCH(N_WATCH)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .st_en_o(st_en), .ld_en_o(ld_en), .if_en_o(if_en),
    .waddr_o(waddr), .mask_o(mask), .apply_o(apply)
  );

  for (genvar g = 0; g < N_WATCH; g++) begin : g_cmp
    watch_cmp #(.AW(AW)) u_cmp (
      .acc_type_i (acc_type_i),
      .acc_word_i (acc_addr_i[PADDR_W-1:WORD_LSB]),
      .st_en_i    (st_en[g]),
      .ld_en_i    (ld_en[g]),
      .if_en_i    (if_en[g]),
      .waddr_i    (waddr[g]),
      .mask_i     (mask),
      .apply_i    (apply[g]),
      .hit_o      (hit[g])
    );
  end

  watch_report #(.N_WATCH(N_WATCH)) u_report (
    .clk_i, .rst_ni, .acc_valid_i, .acc_type_i,
    .hit_i(hit), .exc_o, .exc_code_o, .exc_watch_o
  );
endmodule

// File: rtl/watch_match_chk.sv
module watch_match_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       acc_valid_i,
  input logic [1:0] acc_type_i,
  input logic       exc_o,
  input logic [4:0] exc_code_o,
  input logic [1:0] exc_watch_o
);
  // R5
  no_exc_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !exc_o);
  // R4
  no_exc_after_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_type_i == 2'd3) |=> !exc_o);
  // R6
  fetch_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_type_i == 2'd0) |=> (!exc_o || exc_code_o == 5'd16));
  // R6
  data_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && (acc_type_i == 2'd1 || acc_type_i == 2'd2)) |=> (!exc_o || exc_code_o == 5'd23));
  // R7
  watch_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> exc_watch_o != 2'b00);
  // R8
  quiet_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_o |-> (exc_code_o == 5'd0 && exc_watch_o == 2'b00));
endmodule

bind watch_match_unit watch_match_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i), .acc_type_i(acc_type_i),
  .exc_o(exc_o), .exc_code_o(exc_code_o), .exc_watch_o(exc_watch_o)
);

// File: tb/watch_match_unit_tb.sv
module watch_match_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic        vld = 1'b0;
  logic [1:0]  typ = '0;
  logic [35:0] addr = '0;
  logic        exc;
  logic [4:0]  code;
  logic [1:0]  wid;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  watch_match_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .acc_valid_i(vld), .acc_type_i(typ), .acc_addr_i(addr),
    .exc_o(exc), .exc_code_o(code), .exc_watch_o(wid)
  );

  typedef struct packed {
    logic [1:0]  t;
    logic [35:0] a;
    logic        v;
    logic        e;
    logic [4:0]  c;
    logic [1:0]  w;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{2'd1, 36'h0_0000_1000, 1'b1, 1'b1, 5'd23, 2'b01},
    '{2'd2, 36'h0_0000_103C, 1'b1, 1'b1, 5'd23, 2'b01},
    '{2'd1, 36'h0_0000_1040, 1'b1, 1'b0, 5'd0,  2'b00},
    '{2'd0, 36'h0_0000_1000, 1'b1, 1'b0, 5'd0,  2'b00},
    '{2'd0, 36'h2_0000_0040, 1'b1, 1'b1, 5'd16, 2'b10},
    '{2'd1, 36'h2_0000_0043, 1'b1, 1'b1, 5'd23, 2'b10},
    '{2'd2, 36'h2_0000_0040, 1'b1, 1'b0, 5'd0,  2'b00},
    '{2'd1, 36'h0_0000_1000, 1'b0, 1'b0, 5'd0,  2'b00},
    '{2'd1, 36'h2_0000_0044, 1'b1, 1'b0, 5'd0,  2'b00},
    '{2'd3, 36'h0_0000_1000, 1'b1, 1'b0, 5'd0,  2'b00}
  };

  task automatic check(input string req, input logic e, input logic [4:0] c, input logic [1:0] w);
    checks++;
    if (exc !== e || code !== c || wid !== w) begin
      fails++;
      $display("FAIL %s: got exc=%0b code=%0d watch=%b, expected exc=%0b code=%0d watch=%b",
               req, exc, code, wid, e, c, w);
    end
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic access(input logic [1:0] t, input logic [35:0] a, input logic v);
    @(negedge clk);
    typ = t; addr = a; vld = v;
    @(negedge clk);
    vld = 1'b0;
  endtask

  function automatic logic [63:0] wreg(input logic s, input logic l, input logic f, input logic [35:0] a);
    return {s, l, f, 25'd0, a[35:2], 2'b00};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and no hit before programming
    check("R1", 1'b0, 5'd0, 2'b00);
    access(2'd1, 36'h0, 1'b1);
    check("R1", 1'b0, 5'd0, 2'b00);

    // R2: watch0 load+store, watch1 fetch+load, mask bits 5:2 applied to watch0
    write_reg(2'd0, wreg(1, 1, 0, 36'h0_0000_1000));
    write_reg(2'd1, wreg(0, 1, 1, 36'h2_0000_0040));
    write_reg(2'd2, {28'd0, 30'd0, 4'hF, 2'b01});

    for (int i = 0; i < 10; i++) begin
      access(VEC[i].t, VEC[i].a, VEC[i].v);
      // R3 R4 R5 R6 R7 table vectors
      check($sformatf("R3/R4/R5/R6 vec%0d", i), VEC[i].e, VEC[i].c, VEC[i].w);
    end

    // R2: write to select 3 is ignored
    write_reg(2'd3, 64'd0);
    access(2'd1, 36'h0_0000_1000, 1'b1);
    check("R2 sel3 ignored", 1'b1, 5'd23, 2'b01);

    // R7: both watches hit
    write_reg(2'd1, wreg(0, 1, 0, 36'h0_0000_1008));
    access(2'd1, 36'h0_0000_1008, 1'b1);
    check("R7 both", 1'b1, 5'd23, 2'b11);
    access(2'd1, 36'h0_0000_1000, 1'b1);
    check("R7 single", 1'b1, 5'd23, 2'b01);

    // R3: apply mask to watch1 as well
    write_reg(2'd2, {28'd0, 30'd0, 4'hF, 2'b11});
    access(2'd1, 36'h0_0000_1030, 1'b1);
    check("R3 shared mask", 1'b1, 5'd23, 2'b11);

    // R9: write and access in same cycle use old values
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 64'd0;
    typ = 2'd2; addr = 36'h0_0000_1000; vld = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; vld = 1'b0;
    check("R9 old value", 1'b1, 5'd23, 2'b01);
    access(2'd2, 36'h0_0000_1000, 1'b1);
    check("R9 new value", 1'b0, 5'd0, 2'b00);

    // R5: held valid gives back-to-back pulses, then drops
    @(negedge clk);
    typ = 2'd1; addr = 36'h0_0000_1008; vld = 1'b1;
    @(negedge clk);
    check("R5 first", 1'b1, 5'd23, 2'b10);
    @(negedge clk);
    vld = 1'b0;
    check("R5 second", 1'b1, 5'd23, 2'b10);
    @(negedge clk);
    check("R5 drop", 1'b0, 5'd0, 2'b00);

    // R1: reset clears programmed state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(2'd1, 36'h0_0000_1008, 1'b1);
    check("R1 after reset", 1'b0, 5'd0, 2'b00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule